// File: doc/BRIEF.md
# Condition-Driven Early-Exit Vector Sequencer

This block steps a vector operation through element indices 0 up to VL-1, one element per clock. For each element it takes the result from an external datapath and forms a 4-bit condition field from it: less-than-zero, greater-than-zero, equal-to-zero, and a summary-overflow bit passed in with the result. It then tests one chosen bit of that field against a wanted polarity. Every element that is tested has its condition field written.

The loop stops at the first element whose chosen bit does not have the wanted value. The vector length it reports is then cut to that element's index, so the surviving length covers only the unbroken run of passing elements from index 0. When every element passes, the reported length equals the length it was given. A compare-only mode turns the operation into a pure test: the condition fields are written but no element result ever is.

The block drives the element index to the datapath, and that datapath answers combinationally in the same cycle. The block then issues registered write strobes for a result store and a condition-field store. A one-cycle done pulse marks the end of the loop, and the reported length is valid from that pulse on.

Top module: `ff_fail_first_loop`

## Requirements
- R1: After synchronous reset, done, res_we, cond_we and elem_req are 0 and new_vl is 0.
- R2: The condition field written on wr_cond holds lt (result negative, as signed) in bit 3, gt (result positive) in bit 2, eq (result zero) in bit 1 and the element's elem_so input in bit 0. Exactly one of bits 3..1 is set.
- R3: bit_sel, captured at start, chooses the tested bit by position: value k tests wr_cond[k], so 0 tests so, 1 eq, 2 gt and 3 lt.
- R4: invert, captured at start, sets the wanted polarity. With invert=0 an element passes when the tested bit is 1; with invert=1 it passes when that bit is 0.
- R5: Elements are tested in ascending index order from 0, one per cycle. Every tested element, including the failing one, gets one cond_we pulse with wr_idx equal to its index.
- R6: At the first failing element with index i, the loop ends. done pulses in the same cycle as that element's condition write, new_vl becomes i, and no further writes follow.
- R7: If all VL elements pass, new_vl equals the captured VL and done pulses in the same cycle as the write of element VL-1.
- R8: With cmp_only=1 at start, res_we is never asserted during that loop, while the condition fields are still written.
- R9: With cmp_only=0, res_we is asserted with wr_data equal to the element result for each passing element and never for the failing one, and res_we is only high together with cond_we.
- R10: A start with vl_in=0 makes no writes, and on the following cycle pulses done with new_vl=0.
- R11: A start strobe that arrives while a loop is running is ignored. The running loop completes with its original length and settings.
- R12: new_vl never exceeds the VL captured at start. It is lowered only by a failing test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop when idle |
| vl_in | input | VL_W | Vector length for the loop (0..MAX_VL) |
| bit_sel | input | 2 | Index of the condition bit to test |
| invert | input | 1 | 1: tested bit must be 0 to pass |
| cmp_only | input | 1 | 1: write condition fields only |
| elem_req | output | 1 | High while elements are being tested |
| elem_idx | output | IDX_W | Index of the element being tested |
| elem_data | input | DATA_W | Result of element elem_idx (same cycle) |
| elem_so | input | 1 | Summary-overflow bit of element elem_idx |
| res_we | output | 1 | Result write strobe |
| cond_we | output | 1 | Condition-field write strobe |
| wr_idx | output | IDX_W | Element index for both writes |
| wr_cond | output | 4 | Condition field to store |
| wr_data | output | DATA_W | Element result to store |
| new_vl | output | VL_W | Resulting vector length |
| done | output | 1 | One-cycle end-of-loop pulse |

## Verification
The assertions take for granted that vl_in never exceeds MAX_VL. They also assume that elem_data and elem_so describe the element currently shown on elem_idx, settled before the clock edge. The bench keeps to both: it draws every length from 0 to MAX_VL, and it serves the element inputs from its own array, indexed combinationally by elem_idx, with values that change only when the block moves on. Its random element values are biased toward passing so that long runs, failures at the last index and full-length passes all occur.

// File: rtl/ff_pkg.sv
package ff_pkg;
  localparam int COND_W = 4;
  localparam int CB_SO  = 0;
  localparam int CB_EQ  = 1;
  localparam int CB_GT  = 2;
  localparam int CB_LT  = 3;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/ff_cond_gen.sv
module ff_cond_gen #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]        data,
  input  logic                     so_in,
  output logic [ff_pkg::COND_W-1:0] cond
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (data == '0);
    is_neg  = data[DATA_W-1];
    cond                 = '0;
    cond[ff_pkg::CB_LT]  = is_neg;
    cond[ff_pkg::CB_GT]  = !is_neg && !is_zero;
    cond[ff_pkg::CB_EQ]  = is_zero;
    cond[ff_pkg::CB_SO]  = so_in;
  end
endmodule

// File: rtl/ff_bit_test.sv
module ff_bit_test #(
  parameter int COND_W = 4,
  localparam int SEL_W = $clog2(COND_W)
) (
  input  logic [COND_W-1:0] cond,
  input  logic [SEL_W-1:0]  sel,
  input  logic              invert,
  output logic              pass
);
  logic [COND_W-1:0] bit_hit;

  for (genvar g = 0; g < COND_W; g++) begin : g_sel
    assign bit_hit[g] = (sel == SEL_W'(g)) && cond[g];
  end

  assign pass = (|bit_hit) ^ invert;
endmodule

// File: rtl/ff_elem_ctr.sv
module ff_elem_ctr #(
  parameter int IDX_W = 6,
  parameter int VL_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [VL_W-1:0]  vl_lim,
  output logic [IDX_W-1:0] idx,
  output logic             is_last
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx <= '0;
    end else if (adv) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assign is_last = (VL_W'(idx) == (vl_lim - VL_W'(1)));
endmodule

// File: rtl/ff_fail_first_loop.sv
module ff_fail_first_loop #(
  parameter int DATA_W = 16,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  input  logic [1:0]        bit_sel,
  input  logic              invert,
  input  logic              cmp_only,
  output logic              elem_req,
  output logic [IDX_W-1:0]  elem_idx,
  input  logic [DATA_W-1:0] elem_data,
  input  logic              elem_so,
  output logic              res_we,
  output logic              cond_we,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [3:0]        wr_cond,
  output logic [DATA_W-1:0] wr_data,
  output logic [VL_W-1:0]   new_vl,
  output logic              done
);
  import ff_pkg::*;

  seq_state_t        state;
  logic [VL_W-1:0]   vl_q;
  logic [1:0]        sel_q;
  logic              inv_q;
  logic              cmp_q;
  logic [COND_W-1:0] cond_now;
  logic              pass_now;
  logic              last_now;
  logic              running;
  logic              accept;

  assign running  = (state == ST_RUN);
  assign accept   = (state == ST_IDLE) && start;
  assign elem_req = running;

  ff_cond_gen #(.DATA_W(DATA_W)) cond_i (
    .data  (elem_data),
    .so_in (elem_so),
    .cond  (cond_now)
  );

  ff_bit_test #(.COND_W(COND_W)) test_i (
    .cond   (cond_now),
    .sel    (sel_q),
    .invert (inv_q),
    .pass   (pass_now)
  );

  ff_elem_ctr #(.IDX_W(IDX_W), .VL_W(VL_W)) ctr_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .adv     (running && pass_now && !last_now),
    .vl_lim  (vl_q),
    .idx     (elem_idx),
    .is_last (last_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      vl_q    <= '0;
      sel_q   <= '0;
      inv_q   <= 1'b0;
      cmp_q   <= 1'b0;
      res_we  <= 1'b0;
      cond_we <= 1'b0;
      wr_idx  <= '0;
      wr_cond <= '0;
      wr_data <= '0;
      new_vl  <= '0;
      done    <= 1'b0;
    end else begin
      res_we  <= 1'b0;
      cond_we <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            vl_q  <= vl_in;
            sel_q <= bit_sel;
            inv_q <= invert;
            cmp_q <= cmp_only;
            if (vl_in == '0) begin
              new_vl <= '0;
              done   <= 1'b1;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          cond_we <= 1'b1;
          wr_idx  <= elem_idx;
          wr_cond <= cond_now;
          wr_data <= elem_data;
          res_we  <= pass_now && !cmp_q;
          if (!pass_now) begin
            new_vl <= VL_W'(elem_idx);
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (last_now) begin
            new_vl <= vl_q;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ff_fail_first_loop_chk.sv
module ff_fail_first_loop_chk #(
  parameter int DATA_W = 16,
  parameter int VL_W   = 7,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              elem_req,
  input logic [IDX_W-1:0]  elem_idx,
  input logic              res_we,
  input logic              cond_we,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [3:0]        wr_cond,
  input logic [DATA_W-1:0] wr_data,
  input logic [VL_W-1:0]   new_vl,
  input logic              done,
  input logic [VL_W-1:0]   vl_q,
  input logic [1:0]        sel_q,
  input logic              inv_q,
  input logic              cmp_q
);
  logic wr_pass;
  assign wr_pass = (wr_cond[sel_q] != inv_q);

  a_r2_one_sign_class: assert property (@(posedge clk) disable iff (rst)
    cond_we |-> ($countones(wr_cond[3:1]) == 1));

  a_r5_ascending_idx: assert property (@(posedge clk) disable iff (rst)
    (cond_we && $past(cond_we)) |-> (wr_idx == $past(wr_idx) + IDX_W'(1)));

  a_r5_req_steps: assert property (@(posedge clk) disable iff (rst)
    (elem_req && $past(elem_req)) |-> (elem_idx == $past(elem_idx) + IDX_W'(1)));

  a_r6_fail_truncates: assert property (@(posedge clk) disable iff (rst)
    (cond_we && !wr_pass) |-> (done && (new_vl == VL_W'(wr_idx))));

  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> (!cond_we && !res_we));

  a_r7_full_pass_len: assert property (@(posedge clk) disable iff (rst)
    (done && cond_we && wr_pass) |-> (new_vl == vl_q));

  a_r8_cmp_no_result: assert property (@(posedge clk) disable iff (rst)
    (cmp_q && cond_we) |-> !res_we);

  a_r9_result_needs_pass: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (cond_we && wr_pass));

  a_r10_empty_len: assert property (@(posedge clk) disable iff (rst)
    (done && !cond_we) |-> (new_vl == '0));

  a_r12_len_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_vl <= vl_q));
endmodule

bind ff_fail_first_loop ff_fail_first_loop_chk #(
  .DATA_W(DATA_W), .VL_W(VL_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .elem_req(elem_req), .elem_idx(elem_idx),
  .res_we(res_we), .cond_we(cond_we), .wr_idx(wr_idx), .wr_cond(wr_cond),
  .wr_data(wr_data), .new_vl(new_vl), .done(done), .vl_q(vl_q),
  .sel_q(sel_q), .inv_q(inv_q), .cmp_q(cmp_q)
);

// File: tb/ff_fail_first_loop_tb.sv
module ff_fail_first_loop_tb_top;
  localparam int DATA_W  = 16;
  localparam int MAX_VL  = 64;
  localparam int VL_W    = $clog2(MAX_VL + 1);
  localparam int IDX_W   = $clog2(MAX_VL);
  localparam int CLK_PER = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [VL_W-1:0]   vl_in = '0;
  logic [1:0]        bit_sel = '0;
  logic              invert = 1'b0;
  logic              cmp_only = 1'b0;
  logic              elem_req;
  logic [IDX_W-1:0]  elem_idx;
  logic [DATA_W-1:0] elem_data;
  logic              elem_so;
  logic              res_we, cond_we, done;
  logic [IDX_W-1:0]  wr_idx;
  logic [3:0]        wr_cond;
  logic [DATA_W-1:0] wr_data;
  logic [VL_W-1:0]   new_vl;

  logic [DATA_W-1:0] mem_d [MAX_VL];
  logic              mem_s [MAX_VL];

  int n_chk = 0;
  int n_bad = 0;

  assign elem_data = mem_d[elem_idx];
  assign elem_so   = mem_s[elem_idx];

  always #(CLK_PER/2) clk = ~clk;

  ff_fail_first_loop #(.DATA_W(DATA_W), .MAX_VL(MAX_VL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .bit_sel(bit_sel),
    .invert(invert), .cmp_only(cmp_only), .elem_req(elem_req),
    .elem_idx(elem_idx), .elem_data(elem_data), .elem_so(elem_so),
    .res_we(res_we), .cond_we(cond_we), .wr_idx(wr_idx), .wr_cond(wr_cond),
    .wr_data(wr_data), .new_vl(new_vl), .done(done)
  );

  function automatic logic [3:0] exp_cond(logic [DATA_W-1:0] d, logic s);
    logic lt, eq;
    lt = d[DATA_W-1];
    eq = (d == '0);
    return {lt, !lt && !eq, eq, s};
  endfunction

  function automatic logic passes(logic [3:0] c, logic [1:0] sel, logic inv);
    return c[sel] != inv;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int vl, input logic [1:0] sel, input logic inv,
                          input logic cmp, input int glitch);
    int exp_vl, n_wr, k;
    logic got_done;
    exp_vl = vl;
    for (int i = vl - 1; i >= 0; i--)
      if (!passes(exp_cond(mem_d[i], mem_s[i]), sel, inv)) exp_vl = i;
    @(negedge clk);
    vl_in = VL_W'(vl); bit_sel = sel; invert = inv; cmp_only = cmp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_wr = 0; got_done = 1'b0; k = 0;
    while (!got_done && k < vl + 4) begin
      if (cond_we) begin
        logic [3:0] ec;
        logic ep;
        ec = exp_cond(mem_d[n_wr], mem_s[n_wr]);
        ep = passes(ec, sel, inv);
        check(wr_idx == IDX_W'(n_wr), "R5 index order", int'(wr_idx), n_wr);
        check(wr_cond == ec, "R2/R3/R4 cond field", int'(wr_cond), int'(ec));
        check(res_we == (ep && !cmp), cmp ? "R8 no result write" : "R9 result strobe",
              int'(res_we), int'(ep && !cmp));
        if (res_we)
          check(wr_data == mem_d[n_wr], "R9 result data", int'(wr_data), int'(mem_d[n_wr]));
        n_wr++;
      end else begin
        check(!res_we, "R9 result without cond", int'(res_we), 0);
      end
      if (done) begin
        got_done = 1'b1;
        check(new_vl == VL_W'(exp_vl), (exp_vl == vl) ? "R7 full length" : "R6 truncated length",
              int'(new_vl), exp_vl);
        check(n_wr == ((exp_vl == vl) ? vl : exp_vl + 1), "R5/R10 write count",
              n_wr, (exp_vl == vl) ? vl : exp_vl + 1);
        check(new_vl <= VL_W'(vl), "R12 length bound", int'(new_vl), vl);
      end else begin
        start = (k == glitch) ? 1'b1 : 1'b0;
        if (k == glitch) vl_in = VL_W'(2);
        @(negedge clk);
        start = 1'b0;
        k++;
      end
    end
    check(got_done, "R6/R7 done seen", int'(got_done), 1);
    @(negedge clk);
    check(!cond_we && !res_we && !done, "R6 quiet after done",
          int'({cond_we, res_we, done}), 0);
  endtask

  task automatic fill_const(input logic [DATA_W-1:0] d, input logic s);
    for (int i = 0; i < MAX_VL; i++) begin mem_d[i] = d; mem_s[i] = s; end
  endtask

  task automatic fill_random(input logic [1:0] sel, input logic inv);
    for (int i = 0; i < MAX_VL; i++) begin
      logic want;
      want = ($urandom % 12) != 0;
      for (int t = 0; t < 12; t++) begin
        case ($urandom % 3)
          0: mem_d[i] = '0;
          1: mem_d[i] = DATA_W'($urandom) | {1'b1, {(DATA_W-1){1'b0}}};
          default: mem_d[i] = DATA_W'($urandom) & {1'b0, {(DATA_W-1){1'b1}}};
        endcase
        mem_s[i] = $urandom % 2;
        if (passes(exp_cond(mem_d[i], mem_s[i]), sel, inv) == want) break;
      end
    end
  endtask

  initial begin
    #(CLK_PER * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    fill_const('0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!done && !res_we && !cond_we && !elem_req && new_vl == '0, "R1 reset state",
          int'({done, res_we, cond_we, elem_req}), 0);

    // R10 empty vector
    run_case(0, 2'd1, 1'b0, 1'b0, -1);
    // R7 max length, all zero, test eq
    run_case(MAX_VL, 2'd1, 1'b0, 1'b0, -1);
    // R6 fail at element 0 (eq must be 0, data zero)
    run_case(5, 2'd1, 1'b1, 1'b0, -1);
    // R6 fail at last element
    fill_const(16'd7, 1'b0); mem_d[9] = 16'hFFF0;
    run_case(10, 2'd2, 1'b0, 1'b0, -1);
    // R3 lt test, R4 inverted
    run_case(10, 2'd3, 1'b1, 1'b0, -1);
    // R3 so bit, R8 compare-only
    fill_const(16'd3, 1'b1); mem_s[6] = 1'b0;
    run_case(12, 2'd0, 1'b0, 1'b1, -1);
    // R11 start while running ignored
    fill_const(16'd1, 1'b0);
    run_case(10, 2'd2, 1'b0, 1'b0, 3);

    for (int n = 0; n < 60; n++) begin
      logic [1:0] s;
      logic iv;
      s = 2'($urandom);
      iv = $urandom % 2;
      fill_random(s, iv);
      run_case(int'($urandom % (MAX_VL + 1)), s, iv, ($urandom % 3) == 0,
               (($urandom % 4) == 0) ? 1 : -1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule